// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Detection

This block is the receive side of an asynchronous serial link. It takes the raw receive line and a sampling enable that runs at sixteen times the bit rate. It can flip the polarity of the line, and it rebuilds characters of 8 or 9 bits, least significant bit first, with optional parity. It reports a full data register, framing errors and parity errors. It can also detect a long dominant break of the kind a LIN master sends. Other flags report an active line edge and an idle line, and the idle report follows the standby rules.

Software reaches the block through a small register port with three registers: control, status and data. The full, idle, framing-error and parity-error flags clear through a two-step sequence. Software first reads status and sees the flag set, then reads data. The break and edge flags clear when software writes a one to their bits. Bit rate generation is outside the block; the sampling enable is simply an input.

Top module: `uartRxLin`

## Requirements
- R1: Each bit lasts 16 sampling ticks. The receiver counts ticks from the first low tick of a start bit and votes on the samples at ticks 7, 8 and 9. A start bit whose vote is high is dropped, and a disturbance that covers one of the three samples does not change the received bit.
- R2: Characters arrive least significant bit first. They are 8 bits long, or 9 bits when control bit 2 is 1. Data register (address 2) holds bits 7..0, and bit 8 appears at status bit 4.
- R3: After reset, control (address 0) and status (address 1) read 0. Status bit 0 (data full) sets at the middle of the stop bit of a received character.
- R4: Status bit 2 (framing error) sets in the same cycle as data full when the stop-bit vote is 0.
- R5: Status bit 3 (parity error) sets together with data full only when control bit 0 enables parity. The last character bit is the parity bit. Control bit 1 selects odd parity when 1 and even parity when 0, and the flag sets when the parity does not match.
- R6: Status bits 0–3 clear on a data-register read only when a status read that saw that flag set came earlier. A data read with no such status read before it leaves them set.
- R7: With control bit 4 set, a run of at least 11 dominant bit votes (12 in 9-bit mode), ended by a recessive vote, sets status bit 5. A shorter run does not. Writing 1 to status bit 5 clears it.
- R8: While control bit 4 is 1, no character sets data full, framing error or parity error.
- R9: Status bit 6 sets on every falling edge of the line after polarity selection, that is, on a rising pin edge when inversion is on. Writing 1 to status bit 6 clears it.
- R10: Control bit 3 inverts the line for every use: start, data, stop, break and idle.
- R11: After a qualified start bit, a recessive line held outside a frame for one character time (16 ticks times 10, or times 11 in 9-bit mode) sets status bit 1 once. It does not set again until another start bit qualifies.
- R12: While control bit 5 (standby) is 1, characters do not set data full. An idle character clears standby, and it sets status bit 1 only when control bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Sampling tick, 16 per bit |
| rxPin | input | 1 | Raw receive line |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (drives the clear sequence) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |

## Verification
The bench keeps the default parameters, 16 ticks per bit and a break threshold of 11. It drives the tick on every clock, so one bit lasts exactly 16 clocks. This lets the bench place one-cycle disturbances on a single voting sample and end break runs exactly one bit short of the 8-bit and 9-bit thresholds. The bench waits out a full idle character within a few hundred cycles. It also checks that the idle flag does not set again while the receiver stays quiet.

// File: rtl/uartRxPkg.sv
package uartRxPkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK, RX_HUNT
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic frameStart;
    logic shiftEn;
    logic inFrame;
  } rxStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Control bit positions
  localparam int C_PAR_EN    = 0;
  localparam int C_PAR_ODD   = 1;
  localparam int C_NINE      = 2;
  localparam int C_INV       = 3;
  localparam int C_BRK_EN    = 4;
  localparam int C_STANDBY   = 5;
  localparam int C_IDLE_WAKE = 6;

  // Status bit positions used for write-one-to-clear
  localparam int S_BRK  = 5;
  localparam int S_EDGE = 6;

endpackage

// File: rtl/uartRxDatapath.sv
module uartRxDatapath
  import uartRxPkg::*;
#(
  parameter int OVS     = 16,
  parameter int BRK_LEN = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       rxPin,
  input  logic       invert,
  input  logic       nineBit,
  input  rxStrobe_t  strobe,
  output logic       lineBit,
  output logic       edgeEvt,
  output logic       midPoint,
  output logic       majBit,
  output logic       lastBit,
  output logic       allZero,
  output logic       breakLong,
  output logic       idleHit,
  output logic [8:0] charData
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(OVS * 11 + 1);
  localparam logic [CW-1:0] SMP_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] SMP_MID = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(OVS - 1);
  localparam logic [IW-1:0] IDLE8   = IW'(OVS * 10 - 1);
  localparam logic [IW-1:0] IDLE9   = IW'(OVS * 11 - 1);
  localparam logic [4:0]    BRK8    = 5'(BRK_LEN);
  localparam logic [4:0]    BRK9    = 5'(BRK_LEN + 1);

  logic [1:0]    syncQ;
  logic          prevBit;
  logic [CW-1:0] tickCnt;
  logic          smpA, smpB;
  logic [8:0]    shReg;
  logic [3:0]    bitIdx;
  logic [4:0]    zeroCnt;
  logic [IW-1:0] idleCnt;

  assign lineBit   = syncQ[1] ^ invert;
  assign edgeEvt   = prevBit & ~lineBit;
  assign midPoint  = tickEn & strobe.inFrame & (tickCnt == SMP_MID);
  assign majBit    = (smpA & smpB) | (smpA & lineBit) | (smpB & lineBit);
  assign lastBit   = bitIdx == (nineBit ? 4'd8 : 4'd7);
  assign allZero   = zeroCnt == (nineBit ? 5'd10 : 5'd9);
  assign breakLong = zeroCnt >= (nineBit ? BRK9 : BRK8);
  assign charData  = nineBit ? shReg : {1'b0, shReg[8:1]};
  assign idleHit   = tickEn & ~strobe.inFrame & lineBit &
                     (idleCnt == (nineBit ? IDLE9 : IDLE8));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      prevBit <= 1'b1;
    end else begin
      syncQ   <= {syncQ[0], rxPin};
      prevBit <= lineBit;
    end
  end

  // Bit phase and voting samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      smpA    <= 1'b1;
      smpB    <= 1'b1;
    end else if (strobe.frameStart) begin
      tickCnt <= CW'(1);
    end else if (tickEn && strobe.inFrame) begin
      tickCnt <= (tickCnt == CNT_TOP) ? '0 : tickCnt + 1'b1;
      if (tickCnt == SMP_A) smpA <= lineBit;
      if (tickCnt == SMP_B) smpB <= lineBit;
    end
  end

  // Character assembly and dominant-run count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      bitIdx  <= '0;
      zeroCnt <= '0;
    end else if (strobe.frameStart) begin
      bitIdx  <= '0;
      zeroCnt <= '0;
    end else begin
      if (strobe.shiftEn) begin
        shReg  <= {majBit, shReg[8:1]};
        bitIdx <= bitIdx + 1'b1;
      end
      if (midPoint && !majBit && zeroCnt != 5'd31) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  // Recessive run length outside a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               idleCnt <= '0;
    else if (strobe.inFrame || !lineBit)     idleCnt <= '0;
    else if (tickEn && idleCnt != '1)        idleCnt <= idleCnt + 1'b1;
  end

  p_start_on_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameStart |-> (!lineBit && tickEn));

endmodule

// File: rtl/uartRxControl.sv
module uartRxControl
  import uartRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       lineBit,
  input  logic       edgeEvt,
  input  logic       midPoint,
  input  logic       majBit,
  input  logic       lastBit,
  input  logic       allZero,
  input  logic       breakLong,
  input  logic       idleHit,
  input  logic [8:0] charData,
  output rxStrobe_t  strobe,
  output logic       invert,
  output logic       nineBit
);

  rxState_e   state, nextState;
  logic [7:0] ctrlReg;
  logic [8:0] dataReg;
  logic       rxFull, idleFlag, frameErr, parErr, brkFlag, edgeFlag;
  logic [3:0] armed;
  logic       idleArmed;

  logic brkEn, standby, statRd, dataRd, statWr, ctrlWr;
  logic deliver, brkEvt, idleEvt, startOk, parityBad;

  assign invert    = ctrlReg[C_INV];
  assign nineBit   = ctrlReg[C_NINE];
  assign brkEn     = ctrlReg[C_BRK_EN];
  assign standby   = ctrlReg[C_STANDBY];
  assign statRd    = regRd && regAddr == ADDR_STAT;
  assign dataRd    = regRd && regAddr == ADDR_DATA;
  assign statWr    = regWr && regAddr == ADDR_STAT;
  assign ctrlWr    = regWr && regAddr == ADDR_CTRL;
  assign deliver   = state == RX_STOP && midPoint && !brkEn && !standby;
  assign brkEvt    = state == RX_BREAK && midPoint && majBit && breakLong;
  assign idleEvt   = idleHit && idleArmed;
  assign startOk   = state == RX_START && midPoint && !majBit;
  assign parityBad = (^charData) ^ ctrlReg[C_PAR_ODD];

  always_comb begin
    nextState      = state;
    strobe         = '0;
    strobe.inFrame = state inside {RX_START, RX_DATA, RX_STOP, RX_BREAK};
    case (state)
      RX_IDLE:  if (tickEn && !lineBit) begin
                  nextState         = RX_START;
                  strobe.frameStart = 1'b1;
                end
      RX_START: if (midPoint) nextState = majBit ? RX_IDLE : RX_DATA;
      RX_DATA:  if (midPoint) begin
                  strobe.shiftEn = 1'b1;
                  if (lastBit) nextState = RX_STOP;
                end
      RX_STOP:  if (midPoint)
                  nextState = (brkEn && !majBit && allZero) ? RX_BREAK : RX_HUNT;
      RX_BREAK: if (midPoint && majBit) nextState = RX_HUNT;
      RX_HUNT:  if (tickEn && lineBit) nextState = RX_IDLE;
      default:  nextState = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RX_IDLE;
      ctrlReg   <= '0;
      dataReg   <= '0;
      rxFull    <= 1'b0;
      idleFlag  <= 1'b0;
      frameErr  <= 1'b0;
      parErr    <= 1'b0;
      brkFlag   <= 1'b0;
      edgeFlag  <= 1'b0;
      armed     <= '0;
      idleArmed <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrlWr)       ctrlReg <= regWdata;
      else if (idleEvt) ctrlReg[C_STANDBY] <= 1'b0;
      if (deliver) dataReg <= charData;
      rxFull   <= deliver | (rxFull & ~(dataRd & armed[0]));
      idleFlag <= (idleEvt & (~standby | ctrlReg[C_IDLE_WAKE])) |
                  (idleFlag & ~(dataRd & armed[1]));
      frameErr <= (deliver & ~majBit) | (frameErr & ~(dataRd & armed[2]));
      parErr   <= (deliver & ctrlReg[C_PAR_EN] & parityBad) |
                  (parErr & ~(dataRd & armed[3]));
      if (statRd)      armed <= {parErr, frameErr, idleFlag, rxFull};
      else if (dataRd) armed <= '0;
      brkFlag  <= brkEvt | (brkFlag & ~(statWr & regWdata[S_BRK]));
      edgeFlag <= edgeEvt | (edgeFlag & ~(statWr & regWdata[S_EDGE]));
      if (startOk)      idleArmed <= 1'b1;
      else if (idleEvt) idleArmed <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = ctrlReg;
      ADDR_STAT: regRdata = {1'b0, edgeFlag, brkFlag, dataReg[8],
                             parErr, frameErr, idleFlag, rxFull};
      ADDR_DATA: regRdata = dataReg[7:0];
      default:   regRdata = '0;
    endcase
  end

  p_start_reject_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && midPoint && majBit) |=> state == RX_IDLE);
  p_fe_with_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> rxFull);
  p_pe_with_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErr) |-> (rxFull && $past(ctrlReg[C_PAR_EN])));
  p_seq_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(frameErr) || $fell(rxFull)) |-> $past(dataRd));
  p_brk_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlReg[C_BRK_EN]) |-> !$rose(rxFull));
  p_edge_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(edgeEvt) |-> edgeFlag);
  p_standby_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(standby) |-> !$rose(rxFull));
  p_idle_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> ($past(!standby) || $past(ctrlReg[C_IDLE_WAKE])));

endmodule

// File: rtl/uartRxLin.sv
module uartRxLin
  import uartRxPkg::*;
#(
  parameter int OVS     = 16,
  parameter int BRK_LEN = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       rxPin,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata
);

  rxStrobe_t  strobe;
  logic       invert, nineBit;
  logic       lineBit, edgeEvt, midPoint, majBit, lastBit;
  logic       allZero, breakLong, idleHit;
  logic [8:0] charData;

  uartRxDatapath #(.OVS(OVS), .BRK_LEN(BRK_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxPin(rxPin),
    .invert(invert), .nineBit(nineBit), .strobe(strobe),
    .lineBit(lineBit), .edgeEvt(edgeEvt), .midPoint(midPoint),
    .majBit(majBit), .lastBit(lastBit), .allZero(allZero),
    .breakLong(breakLong), .idleHit(idleHit), .charData(charData)
  );

  uartRxControl i_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .lineBit(lineBit), .edgeEvt(edgeEvt), .midPoint(midPoint),
    .majBit(majBit), .lastBit(lastBit), .allZero(allZero),
    .breakLong(breakLong), .idleHit(idleHit), .charData(charData),
    .strobe(strobe), .invert(invert), .nineBit(nineBit)
  );

endmodule

// File: tb/test_uartRxLin.sv
module test_uartRxLin;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       rxPin = 1'b1;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;

  int  checks = 0;
  int  errors = 0;
  bit  invMode = 1'b0;
  logic [7:0] rdv;

  always #2 clk = ~clk;

  uartRxLin i_uartRxLin (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxPin(rxPin),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Holds a logical line level (before inversion) for n clocks
  task automatic lineFor(input bit v, input int n);
    rxPin = v ^ invMode;
    repeat (n) @(negedge clk);
  endtask

  // Character with an optional one-clock disturbance at cycle 8 of bit gb
  task automatic sendChar(input logic [8:0] v, input int n, input bit stopV, input int gb = -1);
    lineFor(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      if (i == gb) begin
        lineFor(v[i], 8); lineFor(~v[i], 1); lineFor(v[i], 7);
      end else lineFor(v[i], 16);
    end
    lineFor(stopV, 16);
    lineFor(1'b1, 4);
  endtask

  task automatic clearAll();
    logic [7:0] d;
    repeat (200) @(negedge clk);
    rd(2'd1, d); rd(2'd2, d); wr(2'd1, 8'h60);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3 reset state
    rd(2'd0, rdv); chk("R3 reset ctrl", rdv, 8'h00);
    rd(2'd1, rdv); chk("R3 reset status", rdv, 8'h00);

    // R3 R9 R2 R6 basic character
    sendChar(9'h0A5, 8, 1'b1);
    rd(2'd1, rdv); chk("R3 R9 full and edge", rdv, 8'h41);
    rd(2'd2, rdv); chk("R2 data 8-bit", rdv, 8'hA5);
    rd(2'd1, rdv); chk("R6 full cleared by sequence", rdv, 8'h40);
    wr(2'd1, 8'h40);
    rd(2'd1, rdv); chk("R9 edge write-one-clear", rdv, 8'h00);
    clearAll();

    // R4 R6 framing error and unarmed data read
    sendChar(9'h03C, 8, 1'b0);
    rd(2'd2, rdv); chk("R2 data with bad stop", rdv, 8'h3C);
    rd(2'd1, rdv); chk("R4 R6 flags stay without status read", rdv, 8'h45);
    rd(2'd2, rdv);
    rd(2'd1, rdv); chk("R6 fe and full cleared", rdv, 8'h40);
    clearAll();

    // R5 parity
    wr(2'd0, 8'h01);
    sendChar(9'h035, 8, 1'b1);
    rd(2'd1, rdv); chk("R5 even parity good", rdv & 8'h0F, 8'h01);
    clearAll();
    sendChar(9'h0B5, 8, 1'b1);
    rd(2'd1, rdv); chk("R5 even parity bad", rdv & 8'h0F, 8'h09);
    clearAll();
    wr(2'd0, 8'h03);
    sendChar(9'h0B5, 8, 1'b1);
    rd(2'd1, rdv); chk("R5 odd parity good", rdv & 8'h0F, 8'h01);
    clearAll();
    sendChar(9'h035, 8, 1'b1);
    rd(2'd1, rdv); chk("R5 odd parity bad", rdv & 8'h0F, 8'h09);
    clearAll();

    // R2 nine-bit characters
    wr(2'd0, 8'h04);
    sendChar(9'h1A5, 9, 1'b1);
    rd(2'd1, rdv); chk("R2 ninth bit one", rdv & 8'h1F, 8'h11);
    rd(2'd2, rdv); chk("R2 nine-bit low byte", rdv, 8'hA5);
    clearAll();
    sendChar(9'h0A5, 9, 1'b1);
    rd(2'd1, rdv); chk("R2 ninth bit zero", rdv & 8'h1F, 8'h01);
    clearAll();

    // R1 voting and start qualification
    wr(2'd0, 8'h00);
    lineFor(1'b0, 4); lineFor(1'b1, 60);
    rd(2'd1, rdv); chk("R1 short start dropped", rdv & 8'h01, 8'h00);
    clearAll();
    sendChar(9'h000, 8, 1'b1, 3);
    rd(2'd2, rdv); chk("R1 high disturbance ignored", rdv, 8'h00);
    clearAll();
    sendChar(9'h0FF, 8, 1'b1, 5);
    rd(2'd2, rdv); chk("R1 low disturbance ignored", rdv, 8'hFF);
    clearAll();

    // R10 inversion (pin change and control write land on the same edge)
    @(negedge clk); invMode = 1'b1; rxPin = 1'b0;
    wr(2'd0, 8'h08);
    clearAll();
    sendChar(9'h05A, 8, 1'b1);
    rd(2'd1, rdv); chk("R10 R9 inverted full and rising edge", rdv, 8'h41);
    rd(2'd2, rdv); chk("R10 inverted data", rdv, 8'h5A);
    clearAll();
    sendChar(9'h05A, 8, 1'b0);
    rd(2'd1, rdv); chk("R10 inverted stop error", rdv & 8'h04, 8'h04);
    clearAll();
    @(negedge clk); invMode = 1'b0; rxPin = 1'b1;
    wr(2'd0, 8'h00);
    clearAll();

    // R7 R8 break detection
    wr(2'd0, 8'h10);
    lineFor(1'b0, 192); lineFor(1'b1, 40);
    rd(2'd1, rdv); chk("R7 R8 break 12 bits", rdv & 8'h2F, 8'h20);
    wr(2'd1, 8'h20);
    rd(2'd1, rdv); chk("R7 break write-one-clear", rdv & 8'h20, 8'h00);
    clearAll();
    lineFor(1'b0, 160); lineFor(1'b1, 40);
    rd(2'd1, rdv); chk("R7 R8 10 dominant bits", rdv & 8'h2F, 8'h00);
    clearAll();
    sendChar(9'h0A5, 8, 1'b1);
    rd(2'd1, rdv); chk("R8 character suppressed", rdv & 8'h0F, 8'h00);
    clearAll();
    wr(2'd0, 8'h14);
    lineFor(1'b0, 176); lineFor(1'b1, 40);
    rd(2'd1, rdv); chk("R7 nine-bit 11 dominant bits", rdv & 8'h20, 8'h00);
    clearAll();
    lineFor(1'b0, 192); lineFor(1'b1, 40);
    rd(2'd1, rdv); chk("R7 nine-bit 12 dominant bits", rdv & 8'h20, 8'h20);
    clearAll();

    // R11 idle
    wr(2'd0, 8'h00);
    sendChar(9'h011, 8, 1'b1);
    repeat (100) @(negedge clk);
    rd(2'd1, rdv); chk("R11 idle not yet", rdv & 8'h02, 8'h00);
    repeat (120) @(negedge clk);
    rd(2'd1, rdv); chk("R11 idle after char time", rdv & 8'h02, 8'h02);
    rd(2'd2, rdv);
    rd(2'd1, rdv); chk("R6 idle and full cleared", rdv & 8'h03, 8'h00);
    repeat (300) @(negedge clk);
    rd(2'd1, rdv); chk("R11 no repeat idle", rdv & 8'h02, 8'h00);
    clearAll();

    // R12 standby
    wr(2'd0, 8'h20);
    sendChar(9'h0A5, 8, 1'b1);
    rd(2'd1, rdv); chk("R12 standby no full", rdv & 8'h01, 8'h00);
    repeat (220) @(negedge clk);
    rd(2'd1, rdv); chk("R12 idle hidden in standby", rdv & 8'h02, 8'h00);
    rd(2'd0, rdv); chk("R12 idle wakes receiver", rdv, 8'h00);
    clearAll();
    wr(2'd0, 8'h60);
    sendChar(9'h0A5, 8, 1'b1);
    repeat (220) @(negedge clk);
    rd(2'd1, rdv); chk("R12 idle reported with wake enable", rdv & 8'h03, 8'h02);
    rd(2'd0, rdv); chk("R12 standby cleared", rdv, 8'h40);

    finishRun();
  end

endmodule